// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Deadtime Insertion

One instance of this block serves a single phase leg of a power bridge, and three copies serve a three-phase inverter. It accepts two active-low PWM commands: one for the upper switch and one for the lower switch. Each command first passes through its own glitch filter. A filtered command is accepted only after the new level has been held for a set number of clock cycles.

The block decodes the pair of filtered commands into at most one switch request, so a request for both switches turns both off. It then produces the two gate commands. A switch turns off as soon as its filtered request goes away. A switch turns on only after the opposite gate has been off for a minimum number of cycles. If the controller already leaves a longer gap, that gap passes through unchanged. A two-bit enable mask from a fault supervisor can force either gate off on the next clock. Forcing a gate off this way restarts the off-time that the opposite gate has to wait for.

Top module: `hb_phase_drv`

## Requirements
- R1: While reset is applied and right after it is released, both gate outputs are 0. The reset input is asynchronous and active low.
- R2: The inputs are inverting. A filtered `hin_n`=0 with `lin_n`=1 requests `hs_gate`=1. A filtered `hin_n`=1 with `lin_n`=0 requests `ls_gate`=1. `hin_n`=1 with `lin_n`=1 requests both gates 0.
- R3: When both inputs are low, both gates are 0, even if one gate was on just before.
- R4: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R5: A gate turns off FILT_CYC+1 clock edges after its input changes. This includes the first edge that samples the new level. No deadtime is added to a turn-off.
- R6: After a gate falls, the opposite gate stays 0 for at least DT_CYC cycles. The same count applies to both directions.
- R7: A commanded gap of g cycles between one input releasing and the other input asserting yields an output gap of exactly max(g, DT_CYC) cycles. A gap longer than DT_CYC is therefore kept as it is.
- R8: The filter rejects an input pulse shorter than FILT_CYC cycles. A pulse of w ≥ FILT_CYC cycles reaches the gate with its width of w cycles unchanged.
- R9: An enable bit sampled as 0 (`en_hi` for the upper gate, `en_lo` for the lower gate) forces that gate to 0 at the next clock edge. The gate stays 0 for as long as the bit remains 0.
- R10: A gate forced off by its enable bit starts the deadtime for the opposite gate from that edge. The opposite gate then turns on at edge max(FILT_CYC+1, 1+DT_CYC), counted from the edge at which the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hin_n | input | 1 | Upper-switch PWM command, active low |
| lin_n | input | 1 | Lower-switch PWM command, active low |
| en_hi | input | 1 | Supervisor enable for the upper gate, 1 = allowed |
| en_lo | input | 1 | Supervisor enable for the lower gate, 1 = allowed |
| hs_gate | output | 1 | Upper gate command, 1 = conduct |
| ls_gate | output | 1 | Lower gate command, 1 = conduct |

## Verification
Some properties hold on every cycle, and the assertions check these:
- The two gates never overlap.
- A gate never rises before the opposite gate has been off for DT_CYC cycles.
- A cleared enable bit always pulls its gate low on the next edge.
- A filtered level changes only to a value that the input actually held.

Other properties depend on exact cycle counts, and only the bench scenarios show these:
- The exact max(g, DT_CYC) gap over a sweep of commanded gaps in both directions.
- The FILT_CYC+1 turn-off latency.
- That short pulses are removed while longer pulses keep their width.
- The edge at which the opposite gate turns on after an enable-forced turn-off.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Decoded switch request for one phase leg
  typedef struct packed {
    logic hi;
    logic lo;
  } hb_req_t;

  // Counter width able to hold values 0 .. n-1 (at least one bit)
  function automatic int unsigned hb_cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/hb_rst_sync.sv
module hb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/hb_glitch_filt.sv
module hb_glitch_filt #(
  parameter int unsigned FILT_CYC = 70,
  parameter logic        IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  import hb_pkg::*;

  localparam int unsigned CW = hb_cnt_w(FILT_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] run_q, run_d;
  logic          run_en;

  // A differing level must persist until the run counter reaches its end
  always_comb begin
    lvl_d  = lvl_q;
    run_d  = run_q;
    run_en = 1'b0;
    if (din == lvl_q) begin
      run_d  = '0;
      run_en = (run_q != '0);
    end else if (run_q == CNT_LAST) begin
      lvl_d  = din;
      run_d  = '0;
      run_en = 1'b1;
    end else begin
      run_d  = run_q + 1'b1;
      run_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= IDLE_LVL;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (run_en) begin
        run_q <= run_d;
      end
    end
  end

  assign dout = lvl_q;

  // R8
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q == $past(din)));

endmodule

// File: rtl/hb_dt_gate.sv
module hb_dt_gate #(
  parameter int unsigned DT_CYC = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic [1:0] en,
  output logic [1:0] gate
);
  import hb_pkg::*;

  localparam int unsigned CW = hb_cnt_w(DT_CYC);
  localparam logic [CW-1:0] CNT_TOP = CW'(DT_CYC - 1);

  logic [1:0]  gate_q;
  logic [1:0]  gate_d;
  logic [1:0]  off_done;
  int unsigned chk_off_v [2];

  // Index 0 is the upper switch, index 1 the lower switch
  for (genvar i = 0; i < 2; i++) begin : g_side
    localparam int J = 1 - i;

    logic [CW-1:0] off_q, off_d;
    logic          off_en;
    int unsigned   chk_off;

    // Cycles this gate has been off, saturating at DT_CYC-1
    always_comb begin
      off_d  = off_q;
      off_en = 1'b0;
      if (gate_q[i]) begin
        off_d  = '0;
        off_en = (off_q != '0);
      end else if (off_q != CNT_TOP) begin
        off_d  = off_q + 1'b1;
        off_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q <= '0;
      end else if (off_en) begin
        off_q <= off_d;
      end
    end

    assign off_done[i] = !gate_q[i] && (off_q == CNT_TOP);

    // Turn-off is immediate; turn-on waits for the opposite off-time
    assign gate_d[i] = req[i] && en[i] && (gate_q[i] || off_done[J]);

    // Independent off-time tally used only by the checks
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chk_off <= 0;
      end else if (gate_q[i]) begin
        chk_off <= 0;
      end else if (chk_off < DT_CYC) begin
        chk_off <= chk_off + 1;
      end
    end
    assign chk_off_v[i] = chk_off;

    // R6
    min_deadtime_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q[i]) |-> (chk_off_v[J] >= DT_CYC));

    // R9
    enable_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> !gate_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 2'b00;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign gate = gate_q;

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q[0] && gate_q[1]));

endmodule

// File: rtl/hb_phase_drv.sv
module hb_phase_drv #(
  parameter int unsigned FILT_CYC = 70,
  parameter int unsigned DT_CYC   = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hin_n,
  input  logic lin_n,
  input  logic en_hi,
  input  logic en_lo,
  output logic hs_gate,
  output logic ls_gate
);
  import hb_pkg::*;

  logic       rst_sync_n;
  logic [1:0] raw_n;
  logic [1:0] filt_n;
  hb_req_t    req;
  logic [1:0] gate;

  hb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign raw_n = {lin_n, hin_n};

  for (genvar k = 0; k < 2; k++) begin : g_filt
    hb_glitch_filt #(
      .FILT_CYC (FILT_CYC),
      .IDLE_LVL (1'b1)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .din   (raw_n[k]),
      .dout  (filt_n[k])
    );
  end

  // Inverting decode; both asserted means neither switch
  assign req.hi = !filt_n[0] &&  filt_n[1];
  assign req.lo =  filt_n[0] && !filt_n[1];

  hb_dt_gate #(
    .DT_CYC (DT_CYC)
  ) u_dt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   ({req.lo, req.hi}),
    .en    ({en_lo, en_hi}),
    .gate  (gate)
  );

  assign hs_gate = gate[0];
  assign ls_gate = gate[1];

  // R3
  both_asserted_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!filt_n[0] && !filt_n[1]) |=> (!hs_gate && !ls_gate));

  // R1
  reset_off_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!hs_gate && !ls_gate));

endmodule

// File: tb/hb_phase_drv_tb.sv
module hb_phase_drv_tb;

  localparam int F  = 3;
  localparam int DT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hin_n = 1'b1;
  logic lin_n = 1'b1;
  logic en_hi = 1'b1;
  logic en_lo = 1'b1;
  logic hs_gate, ls_gate;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hb_phase_drv #(.FILT_CYC(F), .DT_CYC(DT)) u_dut (
    .clk(clk), .rst_n(rst_n), .hin_n(hin_n), .lin_n(lin_n),
    .en_hi(en_hi), .en_lo(en_lo), .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Source gate on, release it, assert the other side g cycles later
  task automatic xfer(input bit to_hi, input int g);
    int fall = -1;
    int rise = -1;
    bit ovl  = 1'b0;
    int expg;
    hin_n = 1'b1; lin_n = 1'b1; step(F + DT + 4);
    if (to_hi) lin_n = 1'b0; else hin_n = 1'b0;
    step(F + DT + 4);
    hin_n = 1'b1; lin_n = 1'b1;
    if (g == 0) begin
      if (to_hi) hin_n = 1'b0; else lin_n = 1'b0;
    end
    for (int k = 1; k <= F + DT + g + 8; k++) begin
      step(1);
      if (hs_gate && ls_gate) ovl = 1'b1;
      if (fall < 0 && (to_hi ? !ls_gate : !hs_gate)) fall = k;
      if (rise < 0 && (to_hi ? hs_gate : ls_gate)) rise = k;
      if (k == g && g > 0) begin
        if (to_hi) hin_n = 1'b0; else lin_n = 1'b0;
      end
    end
    expg = (g > DT) ? g : DT;
    chk(fall == F + 1, "R5 turn-off latency", fall, F + 1);
    chk((rise - fall) == expg, (g > DT) ? "R7 long gap kept" : "R6 min deadtime",
        rise - fall, expg);
    chk(!ovl, "R4 overlap", ovl, 0);
    hin_n = 1'b1; lin_n = 1'b1;
  endtask

  task automatic pulse(input int w);
    int hi_cnt = 0;
    hin_n = 1'b1; lin_n = 1'b1; step(F + DT + 4);
    hin_n = 1'b0;
    for (int k = 1; k <= w + F + 6; k++) begin
      if (k == w + 1) hin_n = 1'b1;
      step(1);
      if (hs_gate) hi_cnt++;
    end
    chk(hi_cnt == ((w >= F) ? w : 0), "R8 filter width", hi_cnt, (w >= F) ? w : 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    step(3);
    chk(!hs_gate && !ls_gate, "R1 in reset", {hs_gate, ls_gate}, 0);
    rst_n = 1'b1;
    step(3);
    chk(!hs_gate && !ls_gate, "R1 after reset", {hs_gate, ls_gate}, 0);
    step(F + DT + 4);

    // R2 truth table
    hin_n = 1'b0; lin_n = 1'b1; step(F + DT + 4);
    chk({hs_gate, ls_gate} == 2'b10, "R2 hin low", {hs_gate, ls_gate}, 2);
    hin_n = 1'b1; lin_n = 1'b1; step(F + DT + 4);
    chk({hs_gate, ls_gate} == 2'b00, "R2 both high", {hs_gate, ls_gate}, 0);
    hin_n = 1'b1; lin_n = 1'b0; step(F + DT + 4);
    chk({hs_gate, ls_gate} == 2'b01, "R2 lin low", {hs_gate, ls_gate}, 1);

    // R3 both low from each on-state
    hin_n = 1'b0; lin_n = 1'b0; step(F + DT + 4);
    chk({hs_gate, ls_gate} == 2'b00, "R3 both low from ls", {hs_gate, ls_gate}, 0);
    hin_n = 1'b1; lin_n = 1'b1; step(F + DT + 4);
    hin_n = 1'b0; step(F + DT + 4);
    lin_n = 1'b0; step(F + DT + 4);
    chk({hs_gate, ls_gate} == 2'b00, "R3 both low from hs", {hs_gate, ls_gate}, 0);
    hin_n = 1'b1; lin_n = 1'b1;

    // R5 R6 R7 sweep of commanded gaps, both directions
    for (int g = 0; g <= DT + 3; g++) begin
      xfer(1'b1, g);
      xfer(1'b0, g);
    end

    // R8 pulse widths around the filter length
    for (int w = 1; w <= F + 2; w++) pulse(w);

    // R9 enable forces off and holds off
    hin_n = 1'b0; lin_n = 1'b1; step(F + DT + 4);
    chk(hs_gate, "R9 hs on before disable", hs_gate, 1);
    en_hi = 1'b0; step(1);
    chk(!hs_gate, "R9 off next edge", hs_gate, 0);
    step(DT + 4);
    chk(!hs_gate, "R9 held off", hs_gate, 0);
    en_hi = 1'b1; step(2);
    chk(hs_gate, "R9 resumes", hs_gate, 1);

    // R10 disable restarts the opposite deadtime
    en_lo = 1'b0; lin_n = 1'b0; hin_n = 1'b1; step(F + DT + 4);
    chk(!ls_gate && !hs_gate, "R9 lo disabled", {hs_gate, ls_gate}, 0);
    en_lo = 1'b1; lin_n = 1'b1; hin_n = 1'b0; step(F + DT + 4);
    begin
      int rise = -1;
      int expr = ((F + 1) > (1 + DT)) ? (F + 1) : (1 + DT);
      en_hi = 1'b0; hin_n = 1'b1; lin_n = 1'b0;
      for (int k = 1; k <= F + DT + 8; k++) begin
        step(1);
        if (rise < 0 && ls_gate) rise = k;
      end
      chk(rise == expr, "R10 deadtime after disable", rise, expr);
      en_hi = 1'b1;
    end

    finish_run();
  end

endmodule